// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines three reset causes into one internal reset for a processor core. The causes are a bidirectional reset pin, a supply-low flag and a watchdog underflow pulse. The pin is modelled as a sampled level (`pin_in`) plus an open-drain enable (`pull_en`). When `pull_en` is high, the board-level pin is pulled low. Any recognised cause starts one sequence. First the pin is pulled low for a guaranteed width. Then the block waits until the pin reads high again. A fixed internal delay follows, with the core still held in reset. The sequence ends with a single-cycle strobe that tells the core to fetch its reset vector.

The pin level passes through a two-stage synchroniser. A low level must persist for `HOLD_CYC` clock cycles before it counts, so shorter glitches are dropped. A separate flop is set asynchronously by a low pin level and drives `wake_req`. This lets a clock controller restart a halted clock, so the request survives while no clock runs. A cause register records which source started the most recent sequence. Software clears its bits with a write-one-to-clear strobe. `lvd_low` is assumed to be synchronous to `clk`.

The sequencer states are:
- RUN: idle.
- STRETCH: pin pulled low.
- WAIT_PIN: pin released, waiting for it to read high.
- DELAY: internal delay counting.
- FETCH: vector strobe.

The transitions are:
- RUN to STRETCH on any cause.
- STRETCH to WAIT_PIN once the minimum width is met and `lvd_low` is clear.
- WAIT_PIN to DELAY when the synchronised pin reads high.
- DELAY to FETCH when the delay count ends.
- FETCH to RUN unconditionally.
- Any state to STRETCH on a new cause.

The block comes out of `por_n` in STRETCH, with the supply-low cause recorded.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst` and `pull_en` are 1, `vec_fetch` is 0 and `cause` is 3'b010. After release, the sequence completes with exactly one `vec_fetch`.
- R2: A pin low level lasting at least `HOLD_CYC` cycles starts a sequence and loads `cause` with 3'b001. Cause bits are: bit 0 pin, bit 1 supply-low, bit 2 watchdog.
- R3: A pin low level lasting fewer than `HOLD_CYC` cycles has no effect. `pull_en` and `core_rst` stay 0 and `cause` is unchanged.
- R4: For a pin or watchdog cause, `pull_en` is high for exactly `OUT_W` cycles, and `core_rst` is high throughout.
- R5: A rising `lvd_low` starts a sequence and loads `cause` with 3'b010. `pull_en` then stays high for max(H, `OUT_W`) cycles, where H is the number of cycles `lvd_low` stays high.
- R6: A one-cycle `wdg_uf` pulse starts a sequence and loads `cause` with 3'b100.
- R7: After `pull_en` falls, `core_rst` stays high without `pull_en` until `DELAY_CYC` cycles after the synchronised pin reads high. This totals `DELAY_CYC`+3 cycles when nothing else holds the pin. `vec_fetch` is then high for exactly one cycle, with `core_rst` low.
- R8: If the pin is held low externally past the drive window, the delay starts only after the pin is released. `vec_fetch` appears `DELAY_CYC`+3 cycles after the release.
- R9: A new cause arriving during STRETCH or DELAY restarts the sequence from STRETCH with a fresh `OUT_W` count.
- R10: A 1 in `cause_clr` clears that `cause` bit. A 0 leaves the bit alone. A cause arriving in the same cycle wins and replaces the whole register.
- R11: `wake_req` rises as soon as the pin goes low, even with the clock stopped. It falls on the first clock edge after the synchronised pin reads high.
- R12: Pin low levels during STRETCH and WAIT_PIN are not counted as new pin causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_in | input | 1 | Sampled level of the reset pin (low = asserted) |
| lvd_low | input | 1 | Supply-low indication, synchronous, active high |
| wdg_uf | input | 1 | Watchdog underflow pulse |
| cause_clr | input | 3 | Write-one-to-clear strobe for the cause bits |
| pull_en | output | 1 | Open-drain enable that pulls the reset pin low |
| core_rst | output | 1 | Internal reset to the core, active high |
| vec_fetch | output | 1 | One-cycle reset-vector fetch strobe |
| cause | output | 3 | Source of the last reset (bit 0 pin, bit 1 supply-low, bit 2 watchdog) |
| wake_req | output | 1 | Asynchronous request raised by a low pin level |

## Verification
Two functions can coincide in one cycle: a new watchdog cause loading the cause register, and a software clear of all cause bits. The bench drives `wdg_uf` and `cause_clr` = 3'b111 on the same edge while idle. It expects `cause` to read 3'b100 afterwards and a full-width drive to follow. A second coincidence is a qualified-length external low arriving while the block drives the pin itself. The bench judges it by an unchanged watchdog cause and an unaltered `OUT_W` drive width.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_STRETCH  = 3'd1,
        ST_WAIT_PIN = 3'd2,
        ST_DELAY    = 3'd3,
        ST_FETCH    = 3'd4
    } seq_state_e;

    localparam int CAUSE_PIN  = 0;
    localparam int CAUSE_LVD  = 1;
    localparam int CAUSE_WDG  = 2;
    localparam int NUM_CAUSES = 3;

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_in,
    input  logic mask,
    output logic pin_sync,
    output logic hit,
    output logic wake_req
);
    localparam int QW = $clog2(HOLD_CYC + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(HOLD_CYC - 1);
    localparam logic [QW-1:0] Q_SAT  = QW'(HOLD_CYC);

    logic          s1_q;
    logic          s2_q;
    logic [QW-1:0] low_cnt_q;
    logic          wake_q;

    // two-stage synchroniser; idle level of the pin is high
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= pin_in;
            s2_q <= s1_q;
        end
    end

    // width qualifier on the synchronised level
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt_q <= '0;
        end else if (mask || s2_q) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != Q_SAT) begin
            low_cnt_q <= low_cnt_q + QW'(1);
        end
    end

    // request flop set directly by the pin, so it works without a clock
    always_ff @(posedge clk or negedge pin_in or negedge por_n) begin
        if (!por_n) begin
            wake_q <= 1'b0;
        end else if (!pin_in) begin
            wake_q <= 1'b1;
        end else if (s1_q && s2_q) begin
            wake_q <= 1'b0;
        end
    end

    assign pin_sync = s2_q;
    assign hit      = !mask && !s2_q && (low_cnt_q == Q_LAST);
    assign wake_req = wake_q;

    AST_HIT_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        hit |=> !hit); // R2
    AST_WAKE_COVERS_LOW: assert property (@(posedge clk) disable iff (!por_n)
        !pin_sync |-> wake_req); // R11

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int OUT_W     = 32,
    parameter int DELAY_CYC = 4096
) (
    input  logic clk,
    input  logic por_n,
    input  logic ev_any,
    input  logic lvd_low,
    input  logic pin_hi,
    output logic pin_mask,
    output logic pull_en,
    output logic core_rst,
    output logic vec_fetch
);
    localparam int CNT_MAX = (OUT_W > DELAY_CYC) ? OUT_W : DELAY_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] OUT_LAST = CW'(OUT_W - 1);
    localparam logic [CW-1:0] DLY_LAST = CW'(DELAY_CYC - 1);
    localparam int PW      = $clog2(OUT_W + 2);
    localparam logic [PW-1:0] PULL_SAT = PW'(OUT_W + 1);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_STRETCH;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                cnt_d = '0;
            end
            ST_STRETCH: begin
                if (cnt_q == OUT_LAST) begin
                    if (!lvd_low) begin
                        state_d = ST_WAIT_PIN;
                        cnt_d   = '0;
                    end
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_WAIT_PIN: begin
                if (pin_hi) begin
                    state_d = ST_DELAY;
                    cnt_d   = '0;
                end
            end
            ST_DELAY: begin
                if (cnt_q == DLY_LAST) begin
                    state_d = ST_FETCH;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_FETCH: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
            default: begin
                state_d = ST_STRETCH;
                cnt_d   = '0;
            end
        endcase
        if (ev_any) begin
            state_d = ST_STRETCH;
            cnt_d   = '0;
        end
    end

    // output decode
    always_comb begin
        pull_en   = 1'b0;
        core_rst  = 1'b0;
        vec_fetch = 1'b0;
        pin_mask  = 1'b0;
        unique case (state_q)
            ST_RUN: ;
            ST_STRETCH: begin
                pull_en  = 1'b1;
                core_rst = 1'b1;
                pin_mask = 1'b1;
            end
            ST_WAIT_PIN: begin
                core_rst = 1'b1;
                pin_mask = 1'b1;
            end
            ST_DELAY: core_rst = 1'b1;
            ST_FETCH: vec_fetch = 1'b1;
            default: core_rst = 1'b1;
        endcase
    end

    // run length of the pin drive, for the minimum-width check
    logic [PW-1:0] pull_len_q;
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pull_len_q <= '0;
        end else if (!pull_en) begin
            pull_len_q <= '0;
        end else if (pull_len_q != PULL_SAT) begin
            pull_len_q <= pull_len_q + PW'(1);
        end
    end

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        vec_fetch |=> !vec_fetch); // R7
    AST_FETCH_AFTER_RST: assert property (@(posedge clk) disable iff (!por_n)
        vec_fetch |-> $past(core_rst)); // R7
    AST_PULL_MIN_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
        $fell(pull_en) |-> (pull_len_q >= PW'(OUT_W))); // R4
    AST_LVD_HOLDS_PIN: assert property (@(posedge clk) disable iff (!por_n)
        (pull_en && lvd_low) |=> pull_en); // R5
    AST_EVENT_RESTART: assert property (@(posedge clk) disable iff (!por_n)
        ev_any |=> (pull_en && core_rst)); // R9

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
    import rst_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  por_n,
    input  logic [NUM_CAUSES-1:0] ev,
    input  logic [NUM_CAUSES-1:0] clr,
    output logic [NUM_CAUSES-1:0] cause
);
    logic                  any_ev;
    logic [NUM_CAUSES-1:0] cause_q;

    assign any_ev = |ev;

    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_bit
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                cause_q[g] <= (g == CAUSE_LVD);
            end else if (any_ev) begin
                cause_q[g] <= ev[g];
            end else if (clr[g]) begin
                cause_q[g] <= 1'b0;
            end
        end
    end

    assign cause = cause_q;

    AST_CAUSE_NO_SET: assert property (@(posedge clk) disable iff (!por_n)
        !any_ev |=> ((cause & ~$past(cause)) == '0)); // R10
    AST_CAUSE_RECORDED: assert property (@(posedge clk) disable iff (!por_n)
        any_ev |=> (cause != '0)); // R10

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int HOLD_CYC  = 8,
    parameter int OUT_W     = 32,
    parameter int DELAY_CYC = 4096
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pin_in,
    input  logic       lvd_low,
    input  logic       wdg_uf,
    input  logic [2:0] cause_clr,
    output logic       pull_en,
    output logic       core_rst,
    output logic       vec_fetch,
    output logic [2:0] cause,
    output logic       wake_req
);
    logic                  pin_sync;
    logic                  pin_hit;
    logic                  pin_mask;
    logic                  lvd_d_q;
    logic [NUM_CAUSES-1:0] ev;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) lvd_d_q <= 1'b0;
        else        lvd_d_q <= lvd_low;
    end

    always_comb begin
        ev            = '0;
        ev[CAUSE_PIN] = pin_hit;
        ev[CAUSE_LVD] = lvd_low && !lvd_d_q;
        ev[CAUSE_WDG] = wdg_uf;
    end

    rst_pin_qual #(.HOLD_CYC(HOLD_CYC)) u_qual (
        .clk      (clk),
        .por_n    (por_n),
        .pin_in   (pin_in),
        .mask     (pin_mask),
        .pin_sync (pin_sync),
        .hit      (pin_hit),
        .wake_req (wake_req)
    );

    rst_seq_fsm #(.OUT_W(OUT_W), .DELAY_CYC(DELAY_CYC)) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .ev_any    (|ev),
        .lvd_low   (lvd_low),
        .pin_hi    (pin_sync),
        .pin_mask  (pin_mask),
        .pull_en   (pull_en),
        .core_rst  (core_rst),
        .vec_fetch (vec_fetch)
    );

    rst_cause_reg u_cause (
        .clk   (clk),
        .por_n (por_n),
        .ev    (ev),
        .clr   (cause_clr),
        .cause (cause)
    );

    AST_WDG_STARTS: assert property (@(posedge clk) disable iff (!por_n)
        wdg_uf |=> (pull_en && core_rst && cause[CAUSE_WDG])); // R6
    AST_FETCH_NOT_DRIVING: assert property (@(posedge clk) disable iff (!por_n)
        vec_fetch |-> (!pull_en && !core_rst)); // R7

endmodule

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
    localparam int HOLD  = 3;
    localparam int OUTW  = 8;
    localparam int DLY   = 20;

    logic       clk = 1'b0;
    logic       clk_en = 1'b1;
    logic       por_n = 1'b0;
    logic       ext_low = 1'b0;
    logic       lvd_low = 1'b0;
    logic       wdg_uf = 1'b0;
    logic [2:0] cause_clr = 3'b000;
    logic       pin_in;
    logic       pull_en, core_rst, vec_fetch, wake_req;
    logic [2:0] cause;
    int errors = 0;
    int checks = 0;

    assign pin_in = ~(ext_low | pull_en);

    always begin
        #5;
        if (clk_en) clk = ~clk;
    end

    rst_seq_ctrl #(.HOLD_CYC(HOLD), .OUT_W(OUTW), .DELAY_CYC(DLY)) u_dut (
        .clk(clk), .por_n(por_n), .pin_in(pin_in), .lvd_low(lvd_low),
        .wdg_uf(wdg_uf), .cause_clr(cause_clr), .pull_en(pull_en),
        .core_rst(core_rst), .vec_fetch(vec_fetch), .cause(cause),
        .wake_req(wake_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic measure(input int ext_on, input int ext_off, input int lvd_off,
                           input int wdg_at, output int pc, output int rc, output int fc);
        pc = 0; rc = 0; fc = 0;
        for (int i = 1; i <= 5000; i++) begin
            @(negedge clk);
            wdg_uf = 1'b0;
            cause_clr = 3'b000;
            if (pull_en) pc++;
            else if (core_rst) rc++;
            if (vec_fetch) fc++;
            if (i == ext_on)  ext_low = 1'b1;
            if (i == ext_off) ext_low = 1'b0;
            if (i == lvd_off) lvd_low = 1'b0;
            if (i == wdg_at)  wdg_uf = 1'b1;
            if (fc > 0 && !vec_fetch) break;
        end
    endtask

    int pc, rc, fc;

    initial begin
        // R1: reset state
        #22;
        chk(core_rst && pull_en && !vec_fetch, "R1 reset outputs", {pull_en, core_rst, vec_fetch}, 3'b110);
        chk(cause == 3'b010, "R1 reset cause", cause, 3'b010);
        @(negedge clk); por_n = 1'b1;
        measure(-1, -1, -1, -1, pc, rc, fc);
        chk(fc == 1, "R1 fetch after reset", fc, 1);
        chk(rc == DLY + 3, "R7 delay after reset", rc, DLY + 3);

        // R6/R4/R7: watchdog
        @(negedge clk); wdg_uf = 1'b1;
        measure(-1, -1, -1, -1, pc, rc, fc);
        chk(pc == OUTW, "R4 wdg drive width", pc, OUTW);
        chk(rc == DLY + 3, "R7 wdg delay", rc, DLY + 3);
        chk(fc == 1, "R7 wdg single fetch", fc, 1);
        chk(cause == 3'b100, "R6 wdg cause", cause, 3'b100);
        chk(!core_rst, "R7 core out of reset", core_rst, 0);

        // R3/R2: pin pulse width sweep
        for (int len = 1; len <= HOLD + 2; len++) begin
            @(negedge clk); cause_clr = 3'b111;
            @(negedge clk); cause_clr = 3'b000; ext_low = 1'b1;
            if (len < HOLD) begin
                bit seen = 1'b0;
                for (int i = 1; i <= len + 8; i++) begin
                    @(negedge clk);
                    if (pull_en || core_rst) seen = 1'b1;
                    if (i == len) ext_low = 1'b0;
                end
                chk(!seen, "R3 glitch ignored", seen, 0);
                chk(cause == 3'b000, "R3 cause untouched", cause, 0);
            end else begin
                measure(-1, len, -1, -1, pc, rc, fc);
                chk(pc == OUTW, "R4 pin drive width", pc, OUTW);
                chk(rc == DLY + 3, "R7 pin delay", rc, DLY + 3);
                chk(fc == 1, "R2 pin fetch", fc, 1);
                chk(cause == 3'b001, "R2 pin cause", cause, 3'b001);
            end
        end

        // R8: long external pulse
        @(negedge clk); ext_low = 1'b1;
        measure(-1, HOLD + 2 + OUTW + 10, -1, -1, pc, rc, fc);
        chk(pc == OUTW, "R8 long pulse drive", pc, OUTW);
        chk(rc == 10 + DLY + 3, "R8 long pulse delay", rc, 10 + DLY + 3);
        chk(fc == 1, "R8 long pulse fetch", fc, 1);

        // R5: supply-low hold sweep
        for (int h = 1; h <= OUTW + 3; h++) begin
            @(negedge clk); lvd_low = 1'b1;
            measure(-1, -1, h, -1, pc, rc, fc);
            chk(pc == ((h > OUTW) ? h : OUTW), "R5 lvd drive width", pc, (h > OUTW) ? h : OUTW);
            chk(rc == DLY + 3 && fc == 1, "R5 lvd delay and fetch", rc, DLY + 3);
            chk(cause == 3'b010, "R5 lvd cause", cause, 3'b010);
        end

        // R9: restart in STRETCH and in DELAY
        @(negedge clk); wdg_uf = 1'b1;
        measure(-1, -1, -1, 3, pc, rc, fc);
        chk(pc == 3 + OUTW, "R9 restart in stretch", pc, 3 + OUTW);
        chk(fc == 1, "R9 single fetch", fc, 1);
        @(negedge clk); wdg_uf = 1'b1;
        measure(-1, -1, -1, OUTW + 8, pc, rc, fc);
        chk(pc == 2 * OUTW, "R9 restart in delay drive", pc, 2 * OUTW);
        chk(rc == 8 + DLY + 3, "R9 restart in delay wait", rc, 8 + DLY + 3);

        // R12: qualified-length low during our own drive
        @(negedge clk); wdg_uf = 1'b1;
        measure(1, 5, -1, -1, pc, rc, fc);
        chk(pc == OUTW, "R12 drive width unchanged", pc, OUTW);
        chk(cause == 3'b100, "R12 cause stays watchdog", cause, 3'b100);

        // R10: write-one-to-clear and collision
        @(negedge clk); cause_clr = 3'b001;
        @(negedge clk); cause_clr = 3'b000;
        chk(cause == 3'b100, "R10 clear other bit", cause, 3'b100);
        cause_clr = 3'b100;
        @(negedge clk); cause_clr = 3'b000;
        chk(cause == 3'b000, "R10 clear own bit", cause, 0);
        cause_clr = 3'b111; wdg_uf = 1'b1;
        measure(-1, -1, -1, -1, pc, rc, fc);
        chk(cause == 3'b100, "R10 event beats clear", cause, 3'b100);
        chk(pc == OUTW, "R10 collision drive width", pc, OUTW);

        // R11: asynchronous request with the clock stopped
        @(negedge clk); clk_en = 1'b0;
        #3 ext_low = 1'b1;
        #20;
        chk(wake_req, "R11 wake without clock", wake_req, 1);
        chk(!pull_en && !core_rst, "R11 no sequence while halted", pull_en, 0);
        ext_low = 1'b0;
        #10;
        chk(wake_req, "R11 wake latched", wake_req, 1);
        clk_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(!wake_req, "R11 wake cleared", wake_req, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule